// File: doc/BRIEF.md
# Descriptor Ring Walker

This block serves one channel of a memory-to-peripheral transfer engine. Software prepares a ring of 8-byte descriptors in memory. The first 32-bit word of each descriptor holds the control flags and the length. The second word holds the buffer address. Software then tells the channel to poll. The walker fetches the descriptor at its current index. It checks whether the descriptor has been handed to the engine. If so, it reads the buffer address and passes the buffer to a data mover. In this project the mover is a stub that only reports the byte count and the effective start address. The walker then writes the control word back with ownership returned and completion flagged, and moves on to the next slot.

The walker keeps going around the ring on its own until it reaches a descriptor that software still owns. At that point it parks and waits for the next poll. Each finished descriptor produces a one-cycle completion pulse for the interrupt logic. The pulse carries the packet-boundary flags, the slot index, the byte count and the buffer start. Memory is reached through a single request/acknowledge port that handles both reads and writes.

Top module: `dring_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req` and `done_valid` are 0 and `cur_idx` is 0.
- R2: A `poll` pulse while `cfg_enable` is 1 starts a read of the control word at `cfg_base + 8*cur_idx`.
- R3: If bit 31 (ownership, 1 = engine owns) of the fetched control word is 0, the walker returns to idle. It does not write, does not pulse `done_valid`, and leaves `cur_idx` unchanged.
- R4: For an owned descriptor, the walker next reads the buffer address word at `cfg_base + 8*cur_idx + 4`.
- R5: Write-back is a single write to the control word address. The written data is the fetched word with bit 31 cleared, bit 30 (complete) set, and all other bits unchanged.
- R6: Each write-back is followed by exactly one single-cycle `done_valid` pulse. The pulse carries `done_sop` = bit 29, `done_eop` = bit 28, `done_bytes` = bits 15:0, and `done_idx` = the slot index.
- R7: `done_buf` equals the buffer address plus the byte offset. With `cfg_tx` = 1 the offset is bits 27:23 (5 bits). With `cfg_tx` = 0 the offset is bits 25:23 only (3 bits), and bits 27:26 are ignored.
- R8: After each write-back the index advances by one. It wraps to 0 after slot `cfg_len-1`.
- R9: Owned descriptors are processed one after another without further polls, until a non-owned descriptor parks the walker.
- R10: While idle with `cfg_enable` at 0, `cur_idx` is forced to 0 and `poll` is ignored: no memory request is made.
- R11: Once raised, `mem_req` stays high until `mem_ack`, and `mem_addr`, `mem_we` and `mem_wdata` do not change while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Channel on; when low and idle, the index is cleared |
| cfg_tx | input | 1 | 1 = transmit offset field (5 bits), 0 = receive (3 bits) |
| cfg_base | input | ADDR_W | Ring base address, 8-byte aligned |
| cfg_len | input | LEN_W | Number of descriptors in the ring (1 to MAX_DESC) |
| poll | input | 1 | Start walking from the current index |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walker not idle |
| cur_idx | output | IDX_W | Current ring slot |
| done_valid | output | 1 | One-cycle descriptor-complete pulse |
| done_sop | output | 1 | Start-of-packet flag of the finished descriptor |
| done_eop | output | 1 | End-of-packet flag of the finished descriptor |
| done_idx | output | IDX_W | Slot of the finished descriptor |
| done_bytes | output | 16 | Byte count reported by the mover |
| done_buf | output | ADDR_W | Buffer start (address plus offset) |

## Verification
The bench targets these corner cases:
- The receive offset with the two upper bits set. A walker that used the full transmit width here would report a start address up to 24 bytes too high.
- A control word whose complete flag and reserved bits are already set. Write-back must return ownership without disturbing the other fields, and a read-modify-write done wrong would corrupt the length or the flags.
- A three-slot ring walked from one poll. This shows the wrap to slot 0, and the stop on the now-returned first slot. A walker with an off-by-one wrap would skip a slot or read beyond the ring.
- Polling while the channel is off, and a non-owned first descriptor. A faulty walker would issue a write, pulse completion, or keep a stale index there.

// File: rtl/dring_pkg.sv
package dring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTRL,
    ST_RD_ADDR,
    ST_MOVE,
    ST_WB
  } walk_st_e;

  localparam int OWN_BIT = 31;
  localparam int CPL_BIT = 30;
  localparam int SOP_BIT = 29;
  localparam int EOP_BIT = 28;

  // control word as written back: engine gives ownership up, marks complete
  function automatic logic [31:0] wb_word(input logic [31:0] c);
    logic [31:0] w;
    w = c;
    w[OWN_BIT] = 1'b0;
    w[CPL_BIT] = 1'b1;
    return w;
  endfunction

  // byte offset: 5 bits for transmit, 3 bits for receive
  function automatic logic [4:0] buf_offset(input logic [31:0] c, input logic tx);
    return tx ? c[27:23] : {2'b00, c[25:23]};
  endfunction

endpackage

// File: rtl/dring_index.sv
module dring_index #(
  parameter int MAX_DESC = 64,
  parameter int IDX_W    = $clog2(MAX_DESC),
  parameter int LEN_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [LEN_W-1:0] ring_len,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] i,
                                                  input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] nxt;
    nxt = {1'b0, i} + LEN_W'(1);
    return (nxt >= n) ? '0 : nxt[IDX_W-1:0];
  endfunction

  logic last_slot;
  assign last_slot = ({1'b0, idx} + LEN_W'(1)) >= ring_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (adv)   idx <= wrap_next(idx, ring_len);
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !clear && last_slot |=> idx == '0); // R8
  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> idx == '0); // R10

endmodule

// File: rtl/dring_mover.sv
module dring_mover #(
  parameter int ADDR_W = 32,
  parameter int LAT    = 3,
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       len,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [4:0]        offset,
  output logic              done,
  output logic [15:0]       bytes,
  output logic [ADDR_W-1:0] buf_start
);

  logic             active;
  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      bytes     <= '0;
      buf_start <= '0;
    end else if (start) begin
      active    <= 1'b1;
      cnt       <= CNT_W'(LAT);
      bytes     <= len;
      buf_start <= buf_base + ADDR_W'(offset);
    end else if (active) begin
      cnt <= cnt - CNT_W'(1);
      if (done) active <= 1'b0;
    end
  end

  AST_MOVE_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active); // R9
  AST_MOVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dring_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 64,
  parameter int MOVE_LAT = 3,
  localparam int IDX_W   = $clog2(MAX_DESC),
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_tx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              poll,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              done_valid,
  output logic              done_sop,
  output logic              done_eop,
  output logic [IDX_W-1:0]  done_idx,
  output logic [15:0]       done_bytes,
  output logic [ADDR_W-1:0] done_buf
);

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic hi);
    return b + (ADDR_W'(i) << 3) + (hi ? ADDR_W'(4) : ADDR_W'(0));
  endfunction

  walk_st_e st, st_nx;
  logic [31:0] ctrl_q;

  // named internal events
  logic evt_fetch, evt_skip, evt_wb_done, mv_start, mv_done, idx_clear;
  logic [15:0]       mv_bytes;
  logic [ADDR_W-1:0] mv_buf;

  assign evt_fetch   = (st == ST_RD_CTRL) && mem_ack;
  assign evt_skip    = evt_fetch && !mem_rdata[OWN_BIT];
  assign mv_start    = (st == ST_RD_ADDR) && mem_ack;
  assign evt_wb_done = (st == ST_WB) && mem_ack;
  assign idx_clear   = (st == ST_IDLE) && !cfg_enable;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (poll && cfg_enable) st_nx = ST_RD_CTRL;
      ST_RD_CTRL: if (mem_ack) st_nx = mem_rdata[OWN_BIT] ? ST_RD_ADDR : ST_IDLE;
      ST_RD_ADDR: if (mem_ack) st_nx = ST_MOVE;
      ST_MOVE:    if (mv_done) st_nx = ST_WB;
      ST_WB:      if (mem_ack) st_nx = cfg_enable ? ST_RD_CTRL : ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ctrl_q <= '0;
    end else begin
      st <= st_nx;
      if (evt_fetch) ctrl_q <= mem_rdata;
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_RD_CTRL) || (st == ST_RD_ADDR) || (st == ST_WB);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = desc_addr(cfg_base, cur_idx, st == ST_RD_ADDR);
  assign mem_wdata = wb_word(ctrl_q);

  dring_index #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (idx_clear),
    .adv      (evt_wb_done),
    .ring_len (cfg_len),
    .idx      (cur_idx)
  );

  dring_mover #(.ADDR_W(ADDR_W), .LAT(MOVE_LAT)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mv_start),
    .len       (ctrl_q[15:0]),
    .buf_base  (mem_rdata),
    .offset    (buf_offset(ctrl_q, cfg_tx)),
    .done      (mv_done),
    .bytes     (mv_bytes),
    .buf_start (mv_buf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_sop   <= 1'b0;
      done_eop   <= 1'b0;
      done_idx   <= '0;
      done_bytes <= '0;
      done_buf   <= '0;
    end else begin
      done_valid <= evt_wb_done;
      if (evt_wb_done) begin
        done_sop   <= ctrl_q[SOP_BIT];
        done_eop   <= ctrl_q[EOP_BIT];
        done_idx   <= cur_idx;
        done_bytes <= mv_bytes;
        done_buf   <= mv_buf;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN_BIT] && mem_wdata[CPL_BIT]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R6
  AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_skip |=> !busy && !mem_req && !done_valid); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clear |=> !mem_req); // R10

endmodule

// File: tb/test_dring_walker.sv
`timescale 1ns/1ps
module test_dring_walker;

  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int LEN_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_enable = 1'b0, cfg_tx = 1'b0, poll = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [LEN_W-1:0]  cfg_len = LEN_W'(1);
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              busy, done_valid, done_sop, done_eop;
  logic [IDX_W-1:0]  cur_idx, done_idx;
  logic [15:0]       done_bytes;
  logic [ADDR_W-1:0] done_buf;

  dring_walker i_dring_walker (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_tx(cfg_tx),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .cur_idx(cur_idx),
    .done_valid(done_valid), .done_sop(done_sop), .done_eop(done_eop),
    .done_idx(done_idx), .done_bytes(done_bytes), .done_buf(done_buf)
  );

  // memory model: one-cycle acknowledge
  logic [31:0] mem [0:63];
  initial mem_ack = 1'b0;
  initial mem_rdata = '0;
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end
  end

  // logs
  int rd_cnt, wr_cnt, dn_cnt;
  logic [31:0] rd_log [0:31];
  logic [IDX_W-1:0] dn_idx [0:15];
  logic [15:0] dn_bytes [0:15];
  logic dn_eop [0:15];
  logic dn_sop [0:15];
  logic [31:0] dn_buf [0:15];

  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) wr_cnt++;
      else begin
        if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end
    if (done_valid) begin
      if (dn_cnt < 16) begin
        dn_idx[dn_cnt] = done_idx;
        dn_bytes[dn_cnt] = done_bytes;
        dn_eop[dn_cnt] = done_eop;
        dn_sop[dn_cnt] = done_sop;
        dn_buf[dn_cnt] = done_buf;
      end
      dn_cnt++;
    end
  end

  int total = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_cnt = 0; wr_cnt = 0; dn_cnt = 0;
  endtask

  task automatic run_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk("R9 walker parks", {63'd0, busy}, 64'd0);
    repeat (2) @(negedge clk);
  endtask

  // vectors: {tx, ctrl, buffer address}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd31, 7'd0,    16'd64,    32'h1000_0000},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd31, 7'd0,    16'd1500,  32'h2000_0100},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd10, 7'd0,    16'd0,     32'h3000_0000},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd10, 7'd0,    16'hFFFF,  32'hFFFF_FFF0},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0,  7'h55,   16'd7,     32'h0000_0040},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd24, 7'h2A,   16'd2,     32'h0000_0044}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 64; i++) mem[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 done_valid", {63'd0, done_valid}, 64'd0);
    chk("R1 cur_idx", {58'd0, cur_idx}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1; cfg_base = '0; cfg_len = LEN_W'(1);

    // vector table, single-slot ring at address 0
    for (int v = 0; v < NV; v++) begin
      logic        tx;
      logic [31:0] c, a, ob, ew;
      tx = VEC[v][64]; c = VEC[v][63:32]; a = VEC[v][31:0];
      ob = tx ? {27'd0, c[27:23]} : {29'd0, c[25:23]};
      ew = {1'b0, 1'b1, c[29:0]};
      cfg_tx = tx;
      mem[0] = c; mem[1] = a;
      clear_logs();
      run_poll();
      chk("R6 one done", 64'(dn_cnt), 64'd1);
      chk("R6 bytes", {48'd0, dn_bytes[0]}, {48'd0, c[15:0]});
      chk("R6 sop", {63'd0, dn_sop[0]}, {63'd0, c[29]});
      chk("R6 eop", {63'd0, dn_eop[0]}, {63'd0, c[28]});
      chk("R7 buf start", {32'd0, dn_buf[0]}, {32'd0, a + ob});
      chk("R5 writeback", {32'd0, mem[0]}, {32'd0, ew});
      chk("R5 single write", 64'(wr_cnt), 64'd1);
      chk("R4 addr read", {32'd0, rd_log[1]}, 64'd4);
    end

    // three-slot ring at 0x40, one poll
    cfg_base = 32'h40; cfg_len = LEN_W'(3); cfg_tx = 1'b1;
    // disabling while idle clears index first
    cfg_enable = 1'b0; @(negedge clk); @(negedge clk); cfg_enable = 1'b1;
    for (int s = 0; s < 3; s++) begin
      mem[16 + 2*s] = {1'b1, 1'b0, (s == 0), (s == 2), 12'd0, 16'(s + 1)};
      mem[17 + 2*s] = 32'h100 * (s + 1);
    end
    clear_logs();
    run_poll();
    chk("R9 three dones", 64'(dn_cnt), 64'd3);
    for (int s = 0; s < 3; s++) begin
      chk("R8 done idx", {58'd0, dn_idx[s]}, 64'(s));
      chk("R6 ring bytes", {48'd0, dn_bytes[s]}, 64'(s + 1));
      chk("R6 ring eop", {63'd0, dn_eop[s]}, {63'd0, (s == 2)});
    end
    chk("R2 first read addr", {32'd0, rd_log[0]}, 64'h40);
    chk("R4 second read addr", {32'd0, rd_log[1]}, 64'h44);
    chk("R2 next slot read", {32'd0, rd_log[2]}, 64'h48);
    chk("R8 read count", 64'(rd_cnt), 64'd7);
    chk("R8 wrap read addr", {32'd0, rd_log[6]}, 64'h40);
    chk("R8 index wrapped", {58'd0, cur_idx}, 64'd0);

    // R3 non-owned descriptor
    clear_logs();
    run_poll();
    chk("R3 no done", 64'(dn_cnt), 64'd0);
    chk("R3 no write", 64'(wr_cnt), 64'd0);
    chk("R3 one read", 64'(rd_cnt), 64'd1);
    chk("R3 index kept", {58'd0, cur_idx}, 64'd0);
    chk("R3 word unchanged", {32'd0, mem[16]}, 64'h4000_0001 | 64'h2000_0000);

    // park on slot 1, then disable
    mem[16] = {1'b1, 1'b0, 1'b1, 1'b1, 12'd0, 16'd9};
    clear_logs();
    run_poll();
    chk("R9 single done", 64'(dn_cnt), 64'd1);
    chk("R9 parked at slot 1", {58'd0, cur_idx}, 64'd1);
    @(negedge clk); cfg_enable = 1'b0;
    @(negedge clk);
    chk("R10 index cleared", {58'd0, cur_idx}, 64'd0);
    mem[16] = {1'b1, 1'b0, 1'b1, 1'b1, 12'd0, 16'd9};
    clear_logs();
    run_poll();
    chk("R10 poll ignored reads", 64'(rd_cnt), 64'd0);
    chk("R10 poll ignored done", 64'(dn_cnt), 64'd0);
    chk("R10 descriptor untouched", {32'd0, mem[16]}, {32'd0, 1'b1, 1'b0, 1'b1, 1'b1, 12'd0, 16'd9});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule